// File: doc/BRIEF.md
# Dual-Granularity Spare Remapper

This block retires faulty regions of a stacked memory to spare storage at one of two sizes. A fault report names a bank and a row. A bank that has only a few faulty rows has each of those rows redirected to a spare row slot. When a bank collects its fourth distinct faulty row, it is treated as a bank-scale failure. The whole bank is then redirected to a spare bank on the spare die, and the row slots it held are released for reuse. Spare-row tracking costs a table entry per row, and whole-bank sparing spends an entire bank on a few bad rows. Using both keeps the table small and spends spare area only where it is needed. The choice relies on faulty banks falling into two groups: those with very few bad rows and those with thousands.

Every access address passes through a one-cycle translation stage. The bank-remap table is consulted first and the row-remap table second. The registered response carries a kind code and the translated bank and row. When no spare of the needed size is free, a sticky flag is raised and the address is left unchanged. Copying data into a spare is done outside this block.

Fault reports are handled by a four-state controller. IDLE accepts a report while `fault_ready` is high (IDLE→CHECK). CHECK takes one of three paths. If the bank is already on a spare bank, or the row already has a slot, the report is dropped (CHECK→IDLE). If a row slot is needed and one is free, it goes CHECK→ALLOC_ROW; if a spare bank is needed and one is free, it goes CHECK→PROMOTE. If the needed spare is missing, the flag is set and the controller goes CHECK→IDLE. ALLOC_ROW writes the lowest free slot (ALLOC_ROW→IDLE). PROMOTE takes the lowest free spare bank and frees the bank's row slots (PROMOTE→IDLE).

Top module: `dgs_remap`

## Requirements
- R1: Each request with `req_valid` high gives `rsp_valid` high one cycle later. A request that matches no table entry returns kind 0 (pass-through) with its bank and row unchanged.
- R2: A new faulty row in a bank that already holds fewer than 3 row slots takes the lowest free of 16 slots. Lookups of that bank and row then return kind 1, bank 0 and row equal to the slot index.
- R3: A row slot matches only when both the bank and the row equal the stored values. The same row in another bank, or another row in the same bank, passes through.
- R4: A report for a row that already has a slot, or for a bank already on a spare bank, changes no table and consumes no spare.
- R5: The fourth distinct faulty row of a bank takes the lowest free of 2 spare banks. Every row of that bank then returns kind 2, bank equal to the spare-bank index, and the row unchanged. The bank table is checked before the row table.
- R6: On promotion, every row slot held by that bank is freed, and later allocations reuse freed slots lowest index first.
- R7: If a promotion finds no free spare bank, `spares_exhausted` goes high. The bank's existing row slots stay in force, and the new row passes through.
- R8: If a row fault finds no free row slot, `spares_exhausted` goes high and the row passes through.
- R9: After reset, `spares_exhausted` is 0, `fault_ready` is 1, `rsp_valid` is 0 and both tables are empty. Once set, `spares_exhausted` stays high until reset, while later allocations that do find space still proceed.
- R10: A report is taken only while `fault_ready` is high. `fault_ready` is low in the cycle after a report is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_valid | input | 1 | Fault report present |
| fault_bank | input | 3 | Bank of the faulty row |
| fault_row | input | 12 | Faulty row address |
| fault_ready | output | 1 | Controller idle, report will be taken |
| req_valid | input | 1 | Access request present |
| req_bank | input | 3 | Access bank |
| req_row | input | 12 | Access row |
| rsp_valid | output | 1 | Translation result valid |
| rsp_kind | output | 2 | 0 pass-through, 1 spare row, 2 spare bank |
| rsp_bank | output | 3 | Translated bank (spare-bank index for kind 2, 0 for kind 1) |
| rsp_row | output | 12 | Translated row (slot index for kind 1) |
| spares_exhausted | output | 1 | Sticky: a needed spare was unavailable |

## Verification
Lookups are tried with addresses that match nothing, that match only the bank or only the row of a slot, and that hit a slot exactly. These separate a correct two-field compare from a single-field one. Reports are sent as fresh rows, repeated rows and rows of banks already promoted. These separate slot allocation from wrongly consuming spares. A bank is driven to its fourth row to show promotion, slot release and lowest-first reuse. Both kinds of spare are then drained in separate runs, so that bank exhaustion (with slots kept) can be told apart from row exhaustion. Both runs also show that the flag is sticky.

// File: rtl/dgs_pkg.sv
`timescale 1ns/1ps
package dgs_pkg;
    typedef enum logic [1:0] {
        KIND_PASS   = 2'd0,
        KIND_SPROW  = 2'd1,
        KIND_SPBANK = 2'd2
    } remap_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_CHECK     = 2'd1,
        ST_ALLOC_ROW = 2'd2,
        ST_PROMOTE   = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/dgs_row_table.sv
`timescale 1ns/1ps
module dgs_row_table #(
    parameter int ENTRIES = 16,
    parameter int BANK_W  = 3,
    parameter int ROW_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic [BANK_W-1:0] q_bank,
    input  logic [ROW_W-1:0]  q_row,
    output logic              q_dup,
    output logic              q_any,
    output logic              free_ok,
    input  logic              wr_en,
    input  logic              clr_en
);
    logic              ent_v    [ENTRIES];
    logic [BANK_W-1:0] ent_bank [ENTRIES];
    logic [ROW_W-1:0]  ent_row  [ENTRIES];
    logic [IDX_W-1:0]  free_idx;

    always_comb begin
        lk_hit   = 1'b0;
        lk_idx   = '0;
        q_dup    = 1'b0;
        q_any    = 1'b0;
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (ent_v[i] && ent_bank[i] == lk_bank && ent_row[i] == lk_row) begin
                lk_hit = 1'b1;
                lk_idx = IDX_W'(i);
            end
            if (ent_v[i] && ent_bank[i] == q_bank) begin
                q_any = 1'b1;
                if (ent_row[i] == q_row) q_dup = 1'b1;
            end
            if (!ent_v[i]) begin
                free_ok  = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_v[i]    <= 1'b0;
                ent_bank[i] <= '0;
                ent_row[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (clr_en && ent_v[i] && ent_bank[i] == q_bank) ent_v[i] <= 1'b0;
                if (wr_en && free_idx == IDX_W'(i)) begin
                    ent_v[i]    <= 1'b1;
                    ent_bank[i] <= q_bank;
                    ent_row[i]  <= q_row;
                end
            end
        end
    end

    AST_ROW_WRITE_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> free_ok); // R2
    AST_ROW_WRITE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> q_dup); // R4
endmodule

// File: rtl/dgs_bank_table.sv
`timescale 1ns/1ps
module dgs_bank_table #(
    parameter int SPARES  = 2,
    parameter int BANK_W  = 3,
    localparam int SB_W   = (SPARES > 1) ? $clog2(SPARES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    output logic              lk_hit,
    output logic [SB_W-1:0]   lk_idx,
    input  logic [BANK_W-1:0] q_bank,
    output logic              q_hit,
    output logic              free_ok,
    input  logic              alloc_en
);
    logic              sb_v   [SPARES];
    logic [BANK_W-1:0] sb_src [SPARES];
    logic [SB_W-1:0]   free_idx;

    always_comb begin
        lk_hit   = 1'b0;
        lk_idx   = '0;
        q_hit    = 1'b0;
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = SPARES - 1; i >= 0; i--) begin
            if (sb_v[i] && sb_src[i] == lk_bank) begin
                lk_hit = 1'b1;
                lk_idx = SB_W'(i);
            end
            if (sb_v[i] && sb_src[i] == q_bank) q_hit = 1'b1;
            if (!sb_v[i]) begin
                free_ok  = 1'b1;
                free_idx = SB_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SPARES; i++) begin
                sb_v[i]   <= 1'b0;
                sb_src[i] <= '0;
            end
        end else if (alloc_en) begin
            for (int i = 0; i < SPARES; i++) begin
                if (free_idx == SB_W'(i)) begin
                    sb_v[i]   <= 1'b1;
                    sb_src[i] <= q_bank;
                end
            end
        end
    end

    AST_BANK_ALLOC_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> free_ok); // R5
    AST_BANK_ALLOC_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> q_hit); // R5
endmodule

// File: rtl/dgs_fault_ctl.sv
`timescale 1ns/1ps
module dgs_fault_ctl
    import dgs_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter int ROW_W      = 12,
    parameter int PROMOTE_AT = 4,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int CNT_W     = $clog2(PROMOTE_AT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_valid,
    input  logic [BANK_W-1:0] fault_bank,
    input  logic [ROW_W-1:0]  fault_row,
    output logic              fault_ready,
    output logic [BANK_W-1:0] q_bank,
    output logic [ROW_W-1:0]  q_row,
    input  logic              row_dup,
    input  logic              row_bank_any,
    input  logic              row_free,
    input  logic              bank_hit,
    input  logic              bank_free,
    output logic              row_wr,
    output logic              row_clr,
    output logic              bank_alloc,
    output logic              exhausted
);
    ctl_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt [NUM_BANKS];
    logic             need_bank;
    logic             exh_set;

    assign need_bank = (32'(cnt[q_bank]) + 1) >= PROMOTE_AT;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx    = state;
        fault_ready = 1'b0;
        row_wr      = 1'b0;
        row_clr     = 1'b0;
        bank_alloc  = 1'b0;
        exh_set     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                fault_ready = 1'b1;
                if (fault_valid) state_nx = ST_CHECK;
            end
            ST_CHECK: begin
                if (bank_hit || row_dup) begin
                    state_nx = ST_IDLE;
                end else if (need_bank) begin
                    if (bank_free) state_nx = ST_PROMOTE;
                    else begin
                        exh_set  = 1'b1;
                        state_nx = ST_IDLE;
                    end
                end else if (row_free) begin
                    state_nx = ST_ALLOC_ROW;
                end else begin
                    exh_set  = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            ST_ALLOC_ROW: begin
                row_wr   = 1'b1;
                state_nx = ST_IDLE;
            end
            ST_PROMOTE: begin
                bank_alloc = 1'b1;
                row_clr    = 1'b1;
                state_nx   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_bank    <= '0;
            q_row     <= '0;
            exhausted <= 1'b0;
            for (int b = 0; b < NUM_BANKS; b++) cnt[b] <= '0;
        end else begin
            if (fault_ready && fault_valid) begin
                q_bank <= fault_bank;
                q_row  <= fault_row;
            end
            if (exh_set) exhausted <= 1'b1;
            if (row_wr || bank_alloc) cnt[q_bank] <= cnt[q_bank] + 1'b1;
        end
    end

    AST_PROMOTE_FREES_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROMOTE) |=> !row_bank_any); // R6
    AST_EXHAUSTED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        exhausted |=> exhausted); // R9
    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_ready) |=> !fault_ready); // R10
    AST_PROMOTED_NOT_GROWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && bank_hit) |=> $stable(cnt[q_bank])); // R4
endmodule

// File: rtl/dgs_remap.sv
`timescale 1ns/1ps
module dgs_remap
    import dgs_pkg::*;
#(
    parameter int NUM_BANKS   = 8,
    parameter int ROW_W       = 12,
    parameter int ROW_SPARES  = 16,
    parameter int BANK_SPARES = 2,
    parameter int PROMOTE_AT  = 4,
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int IDX_W      = $clog2(ROW_SPARES),
    localparam int SB_W       = (BANK_SPARES > 1) ? $clog2(BANK_SPARES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_valid,
    input  logic [BANK_W-1:0] fault_bank,
    input  logic [ROW_W-1:0]  fault_row,
    output logic              fault_ready,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [BANK_W-1:0] rsp_bank,
    output logic [ROW_W-1:0]  rsp_row,
    output logic              spares_exhausted
);
    logic [BANK_W-1:0] q_bank;
    logic [ROW_W-1:0]  q_row;
    logic              rt_hit, rt_dup, rt_any, rt_free, rt_wr, rt_clr;
    logic [IDX_W-1:0]  rt_idx;
    logic              bt_hit, bt_qhit, bt_free, bt_alloc;
    logic [SB_W-1:0]   bt_idx;

    dgs_row_table #(.ENTRIES(ROW_SPARES), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .lk_bank(req_bank), .lk_row(req_row), .lk_hit(rt_hit), .lk_idx(rt_idx),
        .q_bank(q_bank), .q_row(q_row), .q_dup(rt_dup), .q_any(rt_any),
        .free_ok(rt_free), .wr_en(rt_wr), .clr_en(rt_clr)
    );

    dgs_bank_table #(.SPARES(BANK_SPARES), .BANK_W(BANK_W)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .lk_bank(req_bank), .lk_hit(bt_hit), .lk_idx(bt_idx),
        .q_bank(q_bank), .q_hit(bt_qhit), .free_ok(bt_free), .alloc_en(bt_alloc)
    );

    dgs_fault_ctl #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .PROMOTE_AT(PROMOTE_AT)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .fault_valid(fault_valid), .fault_bank(fault_bank), .fault_row(fault_row),
        .fault_ready(fault_ready), .q_bank(q_bank), .q_row(q_row),
        .row_dup(rt_dup), .row_bank_any(rt_any), .row_free(rt_free),
        .bank_hit(bt_qhit), .bank_free(bt_free),
        .row_wr(rt_wr), .row_clr(rt_clr), .bank_alloc(bt_alloc),
        .exhausted(spares_exhausted)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_kind  <= KIND_PASS;
            rsp_bank  <= '0;
            rsp_row   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (bt_hit) begin
                rsp_kind <= KIND_SPBANK;
                rsp_bank <= BANK_W'(bt_idx);
                rsp_row  <= req_row;
            end else if (rt_hit) begin
                rsp_kind <= KIND_SPROW;
                rsp_bank <= '0;
                rsp_row  <= ROW_W'(rt_idx);
            end else begin
                rsp_kind <= KIND_PASS;
                rsp_bank <= req_bank;
                rsp_row  <= req_row;
            end
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_SPARE_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == KIND_SPBANK) |-> (32'(rsp_bank) < BANK_SPARES)); // R5
    AST_SPARE_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == KIND_SPROW) |-> (32'(rsp_row) < ROW_SPARES)); // R2
endmodule

// File: tb/dgs_remap_test.sv
`timescale 1ns/1ps
module dgs_remap_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_valid = 1'b0;
    logic [2:0]  fault_bank = '0;
    logic [11:0] fault_row = '0;
    logic        fault_ready;
    logic        req_valid = 1'b0;
    logic [2:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [2:0]  rsp_bank;
    logic [11:0] rsp_row;
    logic        spares_exhausted;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0]  kind;
        logic [2:0]  bank;
        logic [11:0] row;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    dgs_remap uut (
        .clk(clk), .rst_n(rst_n),
        .fault_valid(fault_valid), .fault_bank(fault_bank), .fault_row(fault_row),
        .fault_ready(fault_ready),
        .req_valid(req_valid), .req_bank(req_bank), .req_row(req_row),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_bank(rsp_bank), .rsp_row(rsp_row),
        .spares_exhausted(spares_exhausted)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: compares every response against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (sb_q.size() == 0) begin
                failures++;
                $display("FAIL R1 unexpected response actual=valid expected=none");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (rsp_kind !== e.kind || rsp_bank !== e.bank || rsp_row !== e.row) begin
                    failures++;
                    $display("FAIL %s actual=kind%0d/b%0d/r%0d expected=kind%0d/b%0d/r%0d",
                             e.tag, rsp_kind, rsp_bank, rsp_row, e.kind, e.bank, e.row);
                end
            end
        end
    end

    task automatic lookup(input int b, input int r, input int k, input int eb, input int er,
                          input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_bank  = 3'(b);
        req_row   = 12'(r);
        e.kind = 2'(k); e.bank = 3'(eb); e.row = 12'(er); e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic report(input int b, input int r);
        @(negedge clk);
        while (!fault_ready) @(negedge clk);
        fault_valid = 1'b1;
        fault_bank  = 3'(b);
        fault_row   = 12'(r);
        @(negedge clk);
        fault_valid = 1'b0;
        chk(int'(fault_ready), 0, "R10 busy after take");
        while (!fault_ready) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(int'(rsp_valid), 0, "R9 reset rsp_valid");
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(fault_ready), 1, "R9 reset fault_ready");
        chk(int'(spares_exhausted), 0, "R9 reset exhausted");

        // phase A
        lookup(1, 5, 0, 1, 5, "R1 pass-through");
        report(1, 5);
        lookup(1, 5, 1, 0, 0, "R2 row to slot 0");
        lookup(1, 6, 0, 1, 6, "R3 other row same bank");
        lookup(2, 5, 0, 2, 5, "R3 same row other bank");
        report(1, 5);
        report(3, 7);
        lookup(3, 7, 1, 0, 1, "R4 duplicate took no slot");
        report(1, 6);
        report(1, 7);
        lookup(1, 7, 1, 0, 3, "R2 third row slot 3");
        report(1, 8);
        lookup(1, 5, 2, 0, 5, "R5 bank over row");
        lookup(1, 100, 2, 0, 100, "R5 whole bank");
        lookup(3, 7, 1, 0, 1, "R6 other bank slot kept");
        report(4, 9);
        lookup(4, 9, 1, 0, 0, "R6 freed slot reused");
        report(1, 200);
        lookup(1, 200, 2, 0, 200, "R4 promoted bank report");
        chk(int'(spares_exhausted), 0, "R4 no flag on ignored report");
        report(2, 1);
        report(2, 2);
        report(2, 3);
        lookup(2, 3, 1, 0, 4, "R6 lowest-first after free");
        report(2, 4);
        lookup(2, 1, 2, 1, 1, "R5 second spare bank");
        chk(int'(spares_exhausted), 0, "R5 no flag");
        report(5, 1);
        report(5, 2);
        report(5, 3);
        report(5, 4);
        chk(int'(spares_exhausted), 1, "R7 bank spares gone");
        lookup(5, 1, 1, 0, 2, "R7 slots stay");
        lookup(5, 3, 1, 0, 4, "R7 slots stay");
        lookup(5, 4, 0, 5, 4, "R7 new row passes");
        report(6, 1);
        lookup(6, 1, 1, 0, 5, "R9 allocation after flag");
        chk(int'(spares_exhausted), 1, "R9 flag sticky");

        // phase B
        @(negedge clk);
        do_reset();
        @(negedge clk);
        chk(int'(spares_exhausted), 0, "R9 flag cleared by reset");
        chk(int'(fault_ready), 1, "R9 ready after reset");
        lookup(1, 5, 0, 1, 5, "R9 tables cleared");
        for (int b = 0; b < 5; b++)
            for (int r = 0; r < 3; r++)
                report(b, 10 + r);
        report(5, 50);
        chk(int'(spares_exhausted), 0, "R8 sixteen slots fit");
        lookup(5, 50, 1, 0, 15, "R2 last slot");
        lookup(0, 10, 1, 0, 0, "R2 first slot");
        report(5, 51);
        chk(int'(spares_exhausted), 1, "R8 row spares gone");
        lookup(5, 51, 0, 5, 51, "R8 row passes");

        repeat (3) @(negedge clk);
        chk(sb_q.size(), 0, "R1 all responses seen");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule